// File: doc/BRIEF.md
# Core Low-Power State Sequencer

This block follows the low-power state of one processor core. Decoded instruction events move the core from the running state into one of four idle states: a plain halt, a halt entered through a monitor-wait, and two deeper idle levels. Break events and monitor hits bring it back. A separate group of active-low platform inputs (stop-clock, sleep, deep-sleep) takes the core through three nested levels of clock stopping. The block leaves each level only one step at a time. When stop-clock is released it goes back to the idle state it came from.

The block produces the current state as a 3-bit code and a core clock-gate enable. It also drives a flag that allows the platform to stop the bus clock and a one-cycle acknowledge when the core enters stop-grant. Every output is a register and changes on the clock edge that samples the cause. The active-low reset is synchronous. If stop-clock is held low while reset is applied, the core stays in stop-grant rather than going back to running.

Top module: `core_pstate_ctrl`

## Requirements
- R1: While `rstN` is low at a clock edge, the next state is 0 (running) if `stpClkN` is high and 5 (stop-grant) if it is low. No acknowledge is issued for that edge.
- R2: State codes are running=0, halt=1, wait-halt=2, idle level 2=3, idle level 3=4, stop-grant=5, sleep=6, deep sleep=7. From running, `haltEv` enters 1. `mwaitEv` with `mwaitTgt`=1 enters 2, with 2 enters 3, and with 3 enters 4.
- R3: From running, `lvl2Rd` enters 3 and `lvl3Rd` enters 4. When several entry events arrive in the same cycle, the deepest target wins (4 before 3 before 2 before 1).
- R4: `breakEv` returns states 1, 2, 3 and 4 to 0 at the next edge.
- R5: `monHit` returns state 2 to 0. It has no effect in states 1, 3 and 4.
- R6: A low `stpClkN` moves states 0, 1 and 2 to 5 and is ignored in states 3 and 4. In state 5, with `slpN` high, a high `stpClkN` returns to the state held just before stop-grant. Break events and monitor hits are ignored in states 5 to 7.
- R7: `stopGrantAck` is high for exactly one cycle, in the first cycle of stop-grant entered from state 0, 1 or 2. It stays low when stop-grant is re-entered from sleep.
- R8: A low `slpN` moves 5 to 6. A low `dpSlpN` moves 6 to 7 and has no effect in 5. Exit goes one level per edge: 7 to 6 when `dpSlpN` is high, and 6 to 5 when `slpN` is high.
- R9: `coreClkEn` is high only in state 0. `busClkStoppable` is high only in state 7.
- R10: `mwaitEv` with `mwaitTgt`=0 is ignored, and the core stays in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| stpClkN | input | 1 | Active-low stop-clock request |
| slpN | input | 1 | Active-low sleep request |
| dpSlpN | input | 1 | Active-low deep-sleep request |
| haltEv | input | 1 | Halt instruction strobe |
| mwaitEv | input | 1 | Monitor-wait instruction strobe |
| mwaitTgt | input | 2 | Monitor-wait target level (1, 2, 3; 0 ignored) |
| lvl2Rd | input | 1 | Level-2 power-level read strobe |
| lvl3Rd | input | 1 | Level-3 power-level read strobe |
| breakEv | input | 1 | Break event strobe (interrupt, NMI, bus interrupt message) |
| monHit | input | 1 | Monitored-address write strobe |
| pState | output | 3 | Current state code |
| coreClkEn | output | 1 | Core clock enable, high only while running |
| busClkStoppable | output | 1 | Bus clock may be stopped |
| stopGrantAck | output | 1 | One-cycle stop-grant acknowledge |

## Verification
Each result is due exactly one clock edge after the edge that samples its cause. `pState`, `coreClkEn`, `busClkStoppable` and `stopGrantAck` are all registered from the same next-state decision. The bench changes inputs 1 ns after a rising edge and reads outputs 1 ns after the following rising edge, so every check sees one completed transition. Where a step sequence is expected, as in leaving deep sleep or re-entering stop-grant after a break, the bench checks each intermediate edge one by one and does not skip to the end.

// File: rtl/pstate_pkg.sv
package pstate_pkg;

  localparam int STATE_W = 3;
  localparam int TGT_W   = 2;

  typedef enum logic [STATE_W-1:0] {
    PS_RUN   = 3'd0,
    PS_HALT  = 3'd1,
    PS_WHALT = 3'd2,
    PS_IDLE2 = 3'd3,
    PS_IDLE3 = 3'd4,
    PS_SGNT  = 3'd5,
    PS_SLEEP = 3'd6,
    PS_DSLP  = 3'd7
  } pstate_e;

  localparam logic [TGT_W-1:0] TGT_NONE = TGT_W'(0);
  localparam logic [TGT_W-1:0] TGT_L1   = TGT_W'(1);
  localparam logic [TGT_W-1:0] TGT_L2   = TGT_W'(2);
  localparam logic [TGT_W-1:0] TGT_L3   = TGT_W'(3);

  typedef struct packed {
    pstate_e nxt;
    logic    saveRet;
    logic    ackFire;
  } ctrl_strobe_t;

endpackage

// File: rtl/pstate_ctrl.sv
module pstate_ctrl
  import pstate_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               stpClkN,
  input  logic               slpN,
  input  logic               dpSlpN,
  input  logic               haltEv,
  input  logic               mwaitEv,
  input  logic [TGT_W-1:0]   mwaitTgt,
  input  logic               lvl2Rd,
  input  logic               lvl3Rd,
  input  logic               breakEv,
  input  logic               monHit,
  input  pstate_e            curState,
  input  pstate_e            retState,
  output ctrl_strobe_t       strobe
);

  logic wantL3, wantL2, wantL1;
  pstate_e idleTarget;

  // Entry decode from the running state, deepest request first
  always_comb begin
    wantL3 = lvl3Rd || (mwaitEv && mwaitTgt == TGT_L3);
    wantL2 = lvl2Rd || (mwaitEv && mwaitTgt == TGT_L2);
    wantL1 = mwaitEv && mwaitTgt == TGT_L1;
    if (wantL3)      idleTarget = PS_IDLE3;
    else if (wantL2) idleTarget = PS_IDLE2;
    else if (wantL1) idleTarget = PS_WHALT;
    else if (haltEv) idleTarget = PS_HALT;
    else             idleTarget = PS_RUN;
  end

  always_comb begin
    strobe.nxt     = curState;
    strobe.saveRet = 1'b0;
    strobe.ackFire = 1'b0;
    if (!rstN) begin
      strobe.nxt = stpClkN ? PS_RUN : PS_SGNT;
    end else begin
      unique case (curState)
        PS_RUN, PS_HALT, PS_WHALT: begin
          if (!stpClkN) begin
            strobe.nxt     = PS_SGNT;
            strobe.saveRet = 1'b1;
            strobe.ackFire = 1'b1;
          end else if (curState == PS_RUN) begin
            strobe.nxt = idleTarget;
          end else if (breakEv || (curState == PS_WHALT && monHit)) begin
            strobe.nxt = PS_RUN;
          end
        end
        PS_IDLE2, PS_IDLE3: begin
          if (breakEv) strobe.nxt = PS_RUN;
        end
        PS_SGNT: begin
          if (!slpN)        strobe.nxt = PS_SLEEP;
          else if (stpClkN) strobe.nxt = retState;
        end
        PS_SLEEP: begin
          if (!dpSlpN)   strobe.nxt = PS_DSLP;
          else if (slpN) strobe.nxt = PS_SGNT;
        end
        PS_DSLP: begin
          if (dpSlpN) strobe.nxt = PS_SLEEP;
        end
      endcase
    end
  end

  AST_MON_HALT_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (curState == PS_HALT && monHit && !breakEv && stpClkN) |=> (curState == PS_HALT)); // R5

  AST_DEEP_IDLE_IGNORES_STPCLK: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == PS_IDLE2 || curState == PS_IDLE3) && !breakEv) |=> $stable(curState)); // R6

  AST_BREAK_WAKES: assert property (@(posedge clk) disable iff (!rstN)
    ((curState == PS_IDLE2 || curState == PS_IDLE3) && breakEv) |=> (curState == PS_RUN)); // R4

  AST_SGNT_IGNORES_BREAK: assert property (@(posedge clk) disable iff (!rstN)
    (curState == PS_SGNT && slpN && !stpClkN) |=> (curState == PS_SGNT)); // R6

endmodule

// File: rtl/pstate_dp.sv
module pstate_dp
  import pstate_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  ctrl_strobe_t strobe,
  output pstate_e      curState,
  output pstate_e      retState,
  output logic         coreClkEn,
  output logic         busClkStoppable,
  output logic         stopGrantAck
);

  // State and output flags all load from the same next-state value
  always_ff @(posedge clk) begin
    curState        <= strobe.nxt;
    coreClkEn       <= (strobe.nxt == PS_RUN);
    busClkStoppable <= (strobe.nxt == PS_DSLP);
    stopGrantAck    <= rstN && strobe.ackFire;
  end

  // Return point for the way back out of stop-grant
  always_ff @(posedge clk) begin
    if (!rstN)              retState <= PS_RUN;
    else if (strobe.saveRet) retState <= curState;
  end

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    stopGrantAck |=> !stopGrantAck); // R7

  AST_ACK_IN_SGNT: assert property (@(posedge clk) disable iff (!rstN)
    stopGrantAck |-> (curState == PS_SGNT)); // R7

  AST_CLKEN_RUN: assert property (@(posedge clk) disable iff (!rstN)
    coreClkEn == (curState == PS_RUN)); // R9

  AST_BUSSTOP_DSLP: assert property (@(posedge clk) disable iff (!rstN)
    busClkStoppable == (curState == PS_DSLP)); // R9

  AST_DSLP_VIA_SLEEP: assert property (@(posedge clk) disable iff (!rstN)
    (curState == PS_DSLP) |-> ($past(curState) == PS_SLEEP || $past(curState) == PS_DSLP)); // R8

  AST_SLEEP_NEIGHBOURS: assert property (@(posedge clk) disable iff (!rstN)
    (curState == PS_SLEEP) |-> ($past(curState) inside {PS_SGNT, PS_SLEEP, PS_DSLP})); // R8

endmodule

// File: rtl/core_pstate_ctrl.sv
module core_pstate_ctrl
  import pstate_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               stpClkN,
  input  logic               slpN,
  input  logic               dpSlpN,
  input  logic               haltEv,
  input  logic               mwaitEv,
  input  logic [TGT_W-1:0]   mwaitTgt,
  input  logic               lvl2Rd,
  input  logic               lvl3Rd,
  input  logic               breakEv,
  input  logic               monHit,
  output logic [STATE_W-1:0] pState,
  output logic               coreClkEn,
  output logic               busClkStoppable,
  output logic               stopGrantAck
);

  ctrl_strobe_t strobe;
  pstate_e      curState;
  pstate_e      retState;

  pstate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .stpClkN  (stpClkN),
    .slpN     (slpN),
    .dpSlpN   (dpSlpN),
    .haltEv   (haltEv),
    .mwaitEv  (mwaitEv),
    .mwaitTgt (mwaitTgt),
    .lvl2Rd   (lvl2Rd),
    .lvl3Rd   (lvl3Rd),
    .breakEv  (breakEv),
    .monHit   (monHit),
    .curState (curState),
    .retState (retState),
    .strobe   (strobe)
  );

  pstate_dp u_dp (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .curState        (curState),
    .retState        (retState),
    .coreClkEn       (coreClkEn),
    .busClkStoppable (busClkStoppable),
    .stopGrantAck    (stopGrantAck)
  );

  assign pState = curState;

endmodule

// File: tb/core_pstate_ctrl_tb.sv
`timescale 1ns/1ps
module core_pstate_ctrl_tb;

  logic clk = 1'b0;
  logic rstN = 1'b0, stpClkN = 1'b1, slpN = 1'b1, dpSlpN = 1'b1;
  logic haltEv = 1'b0, mwaitEv = 1'b0, lvl2Rd = 1'b0, lvl3Rd = 1'b0;
  logic breakEv = 1'b0, monHit = 1'b0;
  logic [1:0] mwaitTgt = 2'd0;
  logic [2:0] pState;
  logic coreClkEn, busClkStoppable, stopGrantAck;
  int nVec = 0, nBad = 0;

  always #2.5 clk = ~clk;

  core_pstate_ctrl u_dut (
    .clk(clk), .rstN(rstN), .stpClkN(stpClkN), .slpN(slpN), .dpSlpN(dpSlpN),
    .haltEv(haltEv), .mwaitEv(mwaitEv), .mwaitTgt(mwaitTgt), .lvl2Rd(lvl2Rd),
    .lvl3Rd(lvl3Rd), .breakEv(breakEv), .monHit(monHit), .pState(pState),
    .coreClkEn(coreClkEn), .busClkStoppable(busClkStoppable),
    .stopGrantAck(stopGrantAck)
  );

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic [3:0] act, logic [3:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic clearEvents();
    haltEv = 0; mwaitEv = 0; mwaitTgt = 0; lvl2Rd = 0; lvl3Rd = 0;
    breakEv = 0; monHit = 0;
  endtask

  task automatic tReset();
    rstN = 0; stpClkN = 1; step(); step();
    chk("R1 reset to run", pState, 0);
    chk("R9 clken in run", coreClkEn, 1);
    chk("R9 busstop in run", busClkStoppable, 0);
    chk("R7 no ack at reset", stopGrantAck, 0);
    rstN = 1; step();
    chk("R1 run after release", pState, 0);
  endtask

  task automatic tHalt();
    haltEv = 1; step(); clearEvents();
    chk("R2 halt entry", pState, 1);
    chk("R9 clken off in halt", coreClkEn, 0);
    monHit = 1; step(); clearEvents();
    chk("R5 monitor ignored in halt", pState, 1);
    breakEv = 1; step(); clearEvents();
    chk("R4 break wakes halt", pState, 0);
    chk("R9 clken back on", coreClkEn, 1);
  endtask

  task automatic tMwait();
    mwaitEv = 1; mwaitTgt = 1; step(); clearEvents();
    chk("R2 mwait tgt1", pState, 2);
    monHit = 1; step(); clearEvents();
    chk("R5 monitor wakes wait-halt", pState, 0);
    mwaitEv = 1; mwaitTgt = 1; step(); clearEvents();
    breakEv = 1; step(); clearEvents();
    chk("R4 break wakes wait-halt", pState, 0);
    mwaitEv = 1; mwaitTgt = 2; step(); clearEvents();
    chk("R2 mwait tgt2", pState, 3);
    breakEv = 1; step(); clearEvents();
    chk("R4 break wakes idle2", pState, 0);
    mwaitEv = 1; mwaitTgt = 3; step(); clearEvents();
    chk("R2 mwait tgt3", pState, 4);
    monHit = 1; step(); clearEvents();
    chk("R5 monitor ignored in idle3", pState, 4);
    breakEv = 1; step(); clearEvents();
    chk("R4 break wakes idle3", pState, 0);
    mwaitEv = 1; mwaitTgt = 0; step(); clearEvents();
    chk("R10 tgt0 ignored", pState, 0);
    step();
    chk("R10 still running", pState, 0);
  endtask

  task automatic tLevels();
    lvl2Rd = 1; step(); clearEvents();
    chk("R3 level2 read", pState, 3);
    monHit = 1; step(); clearEvents();
    chk("R5 monitor ignored in idle2", pState, 3);
    breakEv = 1; step(); clearEvents();
    lvl3Rd = 1; step(); clearEvents();
    chk("R3 level3 read", pState, 4);
    breakEv = 1; step(); clearEvents();
    haltEv = 1; lvl2Rd = 1; lvl3Rd = 1; mwaitEv = 1; mwaitTgt = 1; step(); clearEvents();
    chk("R3 deepest wins", pState, 4);
    breakEv = 1; step(); clearEvents();
    haltEv = 1; mwaitEv = 1; mwaitTgt = 1; step(); clearEvents();
    chk("R3 wait-halt over halt", pState, 2);
    breakEv = 1; step(); clearEvents();
    chk("R4 back to run", pState, 0);
  endtask

  task automatic tStopGrant();
    stpClkN = 0; step();
    chk("R6 stpclk from run", pState, 5);
    chk("R7 ack on entry", stopGrantAck, 1);
    breakEv = 1; step(); clearEvents();
    chk("R7 ack one cycle", stopGrantAck, 0);
    chk("R6 break ignored in sgnt", pState, 5);
    stpClkN = 1; step();
    chk("R6 return to run", pState, 0);
    haltEv = 1; step(); clearEvents();
    stpClkN = 0; step();
    chk("R6 stpclk from halt", pState, 5);
    chk("R7 ack from halt", stopGrantAck, 1);
    stpClkN = 1; step();
    chk("R6 return to halt", pState, 1);
    breakEv = 1; step(); clearEvents();
    lvl2Rd = 1; step(); clearEvents();
    stpClkN = 0; step();
    chk("R6 stpclk ignored in idle2", pState, 3);
    chk("R7 no ack in idle2", stopGrantAck, 0);
    breakEv = 1; step(); clearEvents();
    chk("R4 break with stpclk low", pState, 0);
    step();
    chk("R6 then stop-grant", pState, 5);
    chk("R7 ack after break", stopGrantAck, 1);
    stpClkN = 1; step();
    chk("R6 return to run again", pState, 0);
  endtask

  task automatic tSleep();
    stpClkN = 0; step(); step();
    dpSlpN = 0; step();
    chk("R8 deep-sleep ignored in sgnt", pState, 5);
    dpSlpN = 1; slpN = 0; step();
    chk("R8 sleep entry", pState, 6);
    dpSlpN = 0; step();
    chk("R8 deep sleep entry", pState, 7);
    chk("R9 busstop in dslp", busClkStoppable, 1);
    breakEv = 1; step(); clearEvents();
    chk("R6 break ignored in dslp", pState, 7);
    dpSlpN = 1; step();
    chk("R8 dslp to sleep", pState, 6);
    chk("R9 busstop off", busClkStoppable, 0);
    slpN = 1; step();
    chk("R8 sleep to sgnt", pState, 5);
    chk("R7 no ack from sleep", stopGrantAck, 0);
    stpClkN = 1; step();
    chk("R6 return after sleep", pState, 0);
  endtask

  task automatic tResetHold();
    stpClkN = 0; step();
    rstN = 0; step();
    chk("R1 reset holds sgnt", pState, 5);
    chk("R7 no ack in reset", stopGrantAck, 0);
    rstN = 1; step();
    chk("R1 sgnt after release", pState, 5);
    stpClkN = 1; step();
    chk("R1 run after stpclk release", pState, 0);
    stpClkN = 0; step(); slpN = 0; step(); dpSlpN = 0; step();
    rstN = 0; stpClkN = 1; slpN = 1; dpSlpN = 1; step();
    chk("R1 reset from dslp", pState, 0);
    chk("R9 busstop cleared", busClkStoppable, 0);
    rstN = 1; step();
  endtask

  initial begin
    step();
    tReset();
    tHalt();
    tMwait();
    tLevels();
    tStopGrant();
    tSleep();
    tResetHold();
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    #400000;
    nBad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule